// File: doc/BRIEF.md
# Cascaded Event Interrupt Aggregator

This block gathers numbered event pulses from many sources into three 32-bit pending words. Each event sets one sticky bit. Three level interrupt lines, called A, B and C, each have their own enable mask for every word. A line stays high while any pending bit that its mask enables is set.

Word 0 is the root word. Its two top bits summarise the two upper words: bit 30 marks activity in word 1 and bit 31 marks activity in word 2. Software cannot clear these summary bits directly. They clear only when the word they stand for drains to zero through a permitted path.

The three words follow different clearing rules. Word 0 clears by write-one except its summary bits. Word 1 ignores software writes and drains only through the hardware clear input. Word 2 clears by write-one and drops its summary bit when it empties.

The register port is a flat, single-cycle access port. Reads are combinational. Writes take effect at the next clock edge.

Top module: `event_irq_agg`

## Requirements
- R1: An event number has 7 bits. Bits 6:5 pick the pending word and bits 4:0 pick the bit in that word. When bits 6:5 equal 3, the event does nothing.
- R2: An event in word 1 also sets word 0 bit 30. An event in word 2 also sets word 0 bit 31.
- R3: Output bit k is high when, in some word w, a pending bit is set together with the same bit of mask k for word w. Output bit 0 is A, bit 1 is B and bit 2 is C.
- R4: An output goes low only when pending AND its mask is zero in all three words. Outputs follow the registers combinationally, so a mask change acts in the cycle after its write edge.
- R5: A register write to pending word 0 clears every bit written as one, except bits 31 and 30, which keep their value.
- R6: A register write to pending word 1 changes nothing.
- R7: A register write to pending word 2 clears the bits written as one. If word 2 is zero afterwards, word 0 bit 31 is cleared.
- R8: A hardware clear removes the one event bit it names, using the R1 encoding. If that leaves word 1 empty, word 0 bit 30 is cleared. If it leaves word 2 empty, word 0 bit 31 is cleared.
- R9: When an event set and any clear hit the same bit in the same cycle, the bit ends up set.
- R10: The register address has 4 bits. Bits 3:2 pick the kind: 0 is pending, 1 is mask A, 2 is mask B and 3 is mask C. Bits 1:0 pick the word. Mask registers are read/write. Word index 3 reads as zero and ignores writes.
- R11: After reset, all pending words and masks are zero and all outputs are low.
- R12: Read data shows the addressed register in the same cycle the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtValid | input | 1 | Event pulse strobe |
| evtNum | input | 7 | Event number |
| hwClrValid | input | 1 | Hardware clear strobe |
| hwClrNum | input | 7 | Event number to clear |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address (kind, word) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data |
| irqOut | output | 3 | Level interrupts {C, B, A} |

## Verification
The hardest states to reach are those where a summary bit must drop. This needs an upper word to become exactly empty through a permitted path, sometimes in the same cycle as a set or a competing clear. Random traffic almost never drains word 2 to exactly zero while bit 31 is enabled on an output. Directed sequences therefore build a known word content first, then peel it off bit by bit through both the register path and the hardware clear. After that, collisions of set and clear on one bit are forced on purpose. A behavioural model running alongside, with masks drawn at random, keeps the outputs and read data honest in every cycle.

// File: rtl/event_irq_agg_pkg.sv
package event_irq_agg_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 3;
  localparam int NUM_OUT   = 3;
  localparam int BIT_W     = $clog2(WORD_W);
  localparam int WSEL_W    = 2;
  localparam int EVT_W     = BIT_W + WSEL_W;
  localparam int KIND_W    = 2;
  localparam int ADDR_W    = KIND_W + WSEL_W;
  localparam int CASC1_BIT = WORD_W - 2;
  localparam int CASC2_BIT = WORD_W - 1;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t [NUM_WORDS-1:0]                setBits;
    word_t [NUM_WORDS-1:0]                clrBits;
    logic                                 casc1Chk;
    logic                                 casc2Chk;
    logic [NUM_OUT-1:0][NUM_WORDS-1:0]    maskWe;
    word_t                                wrData;
  } strobe_t;
endpackage

// File: rtl/event_irq_agg_ctrl.sv
module event_irq_agg_ctrl
  import event_irq_agg_pkg::*;
(
  input  logic              evtValid,
  input  logic [EVT_W-1:0]  evtNum,
  input  logic              hwClrValid,
  input  logic [EVT_W-1:0]  hwClrNum,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  word_t             regWrData,
  output strobe_t           strb
);
  logic [WSEL_W-1:0] evW, clW, wIdx;
  logic [BIT_W-1:0]  evB, clB;
  logic [KIND_W-1:0] kind;
  word_t             cascKeep;

  assign evW  = evtNum[EVT_W-1:BIT_W];
  assign evB  = evtNum[BIT_W-1:0];
  assign clW  = hwClrNum[EVT_W-1:BIT_W];
  assign clB  = hwClrNum[BIT_W-1:0];
  assign kind = regAddr[ADDR_W-1:WSEL_W];
  assign wIdx = regAddr[WSEL_W-1:0];
  assign cascKeep = ~((word_t'(1) << CASC1_BIT) | (word_t'(1) << CASC2_BIT));

  always_comb begin
    strb = '0;
    strb.wrData = regWrData;
    // event decode and cascade summary set
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (evtValid && evW == WSEL_W'(w)) strb.setBits[w][evB] = 1'b1;
      if (hwClrValid && clW == WSEL_W'(w)) strb.clrBits[w][clB] = 1'b1;
    end
    if (evtValid && evW == WSEL_W'(1)) strb.setBits[0][CASC1_BIT] = 1'b1;
    if (evtValid && evW == WSEL_W'(2)) strb.setBits[0][CASC2_BIT] = 1'b1;
    strb.casc1Chk = hwClrValid && clW == WSEL_W'(1);
    strb.casc2Chk = hwClrValid && clW == WSEL_W'(2);
    // software clears: word 0 spares summary bits, word 1 ignored
    if (regWrEn && kind == '0) begin
      if (wIdx == WSEL_W'(0)) strb.clrBits[0] = strb.clrBits[0] | (regWrData & cascKeep);
      if (wIdx == WSEL_W'(2)) begin
        strb.clrBits[2] = strb.clrBits[2] | regWrData;
        strb.casc2Chk   = 1'b1;
      end
    end
    for (int k = 0; k < NUM_OUT; k++)
      for (int w = 0; w < NUM_WORDS; w++)
        if (regWrEn && kind == KIND_W'(k + 1) && wIdx == WSEL_W'(w))
          strb.maskWe[k][w] = 1'b1;
  end

  always_comb begin
    if (regWrEn && kind == '0 && wIdx == WSEL_W'(1) && !hwClrValid)
      AST_W1_SW_IGNORED: assert (strb.clrBits[1] == '0); // R6
  end
endmodule

// File: rtl/event_irq_agg_dp.sv
module event_irq_agg_dp
  import event_irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] rdAddr,
  output word_t             rdData,
  output logic [NUM_OUT-1:0] irqOut
);
  word_t [NUM_WORDS-1:0]                 pendQ, pendNxt;
  logic  [NUM_OUT-1:0][NUM_WORDS-1:0][WORD_W-1:0] maskQ;

  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++)
      pendNxt[w] = (pendQ[w] & ~strb.clrBits[w]) | strb.setBits[w];
    if (strb.casc1Chk && pendNxt[1] == '0)
      pendNxt[0][CASC1_BIT] = strb.setBits[0][CASC1_BIT];
    if (strb.casc2Chk && pendNxt[2] == '0)
      pendNxt[0][CASC2_BIT] = strb.setBits[0][CASC2_BIT];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= pendNxt;
  end

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 maskQ[k][w] <= '0;
        else if (strb.maskWe[k][w]) maskQ[k][w] <= strb.wrData;
      end
    end

    always_comb begin
      irqOut[k] = 1'b0;
      for (int w = 0; w < NUM_WORDS; w++)
        irqOut[k] = irqOut[k] | (|(pendQ[w] & maskQ[k][w]));
    end

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (irqOut[k] && strb.clrBits == '0 && !strb.casc1Chk && !strb.casc2Chk
       && strb.maskWe[k] == '0) |=> irqOut[k]); // R4
  end

  always_comb begin
    rdData = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (rdAddr == ADDR_W'(w)) rdData = pendQ[w];
      for (int k = 0; k < NUM_OUT; k++)
        if (rdAddr == ADDR_W'(((k + 1) << WSEL_W) + w)) rdData = maskQ[k][w];
    end
  end

  AST_CASC1_SET: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.setBits[1]) |=> pendQ[0][CASC1_BIT]); // R2
  AST_CASC2_SET: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.setBits[2]) |=> pendQ[0][CASC2_BIT]); // R2

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_chk
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
      (|strb.setBits[w]) |=> ((pendQ[w] & $past(strb.setBits[w])) == $past(strb.setBits[w]))); // R9
  end
endmodule

// File: rtl/event_irq_agg.sv
module event_irq_agg
  import event_irq_agg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        evtValid,
  input  logic [6:0]  evtNum,
  input  logic        hwClrValid,
  input  logic [6:0]  hwClrNum,
  input  logic        regWrEn,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic [2:0]  irqOut
);
  strobe_t strb;

  event_irq_agg_ctrl u_ctrl (
    .evtValid  (evtValid),
    .evtNum    (evtNum),
    .hwClrValid(hwClrValid),
    .hwClrNum  (hwClrNum),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .strb      (strb)
  );

  event_irq_agg_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .rdAddr (regAddr),
    .rdData (regRdData),
    .irqOut (irqOut)
  );
endmodule

// File: tb/event_irq_agg_test.sv
`timescale 1ns/1ps
module event_irq_agg_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evtValid = 1'b0;
  logic [6:0]  evtNum = '0;
  logic        hwClrValid = 1'b0;
  logic [6:0]  hwClrNum = '0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [2:0]  irqOut;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  event_irq_agg uut (.*);

  // behavioural reference model
  logic [31:0] mPend [3];
  logic [31:0] mMask [3][3];
  logic [31:0] setv [3];
  logic [31:0] clrv [3];
  logic [31:0] nx [3];
  bit c1, c2;

  initial begin
    for (int w = 0; w < 3; w++) begin
      mPend[w] = '0;
      for (int k = 0; k < 3; k++) mMask[k][w] = '0;
    end
  end

  function automatic logic [31:0] mRead(input logic [3:0] a);
    if (a[1:0] == 2'd3) return '0;
    if (a[3:2] == 2'd0) return mPend[a[1:0]];
    return mMask[a[3:2] - 1][a[1:0]];
  endfunction

  function automatic logic [2:0] mIrq();
    logic [2:0] r = '0;
    for (int k = 0; k < 3; k++)
      for (int w = 0; w < 3; w++)
        if ((mPend[w] & mMask[k][w]) != 0) r[k] = 1'b1;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < 3; w++) begin
        mPend[w] = '0;
        for (int k = 0; k < 3; k++) mMask[k][w] = '0;
      end
    end else begin
      c1 = 0; c2 = 0;
      for (int w = 0; w < 3; w++) begin setv[w] = '0; clrv[w] = '0; end
      if (evtValid && evtNum[6:5] != 2'd3) begin
        setv[evtNum[6:5]] |= 32'h1 << evtNum[4:0];
        if (evtNum[6:5] == 2'd1) setv[0] |= 32'h4000_0000;
        if (evtNum[6:5] == 2'd2) setv[0] |= 32'h8000_0000;
      end
      if (hwClrValid && hwClrNum[6:5] != 2'd3) begin
        clrv[hwClrNum[6:5]] |= 32'h1 << hwClrNum[4:0];
        c1 = (hwClrNum[6:5] == 2'd1);
        c2 = (hwClrNum[6:5] == 2'd2);
      end
      if (regWrEn && regAddr[1:0] != 2'd3) begin
        if (regAddr[3:2] == 2'd0) begin
          if (regAddr[1:0] == 2'd0) clrv[0] |= regWrData & 32'h3FFF_FFFF;
          if (regAddr[1:0] == 2'd2) begin clrv[2] |= regWrData; c2 = 1; end
        end else mMask[regAddr[3:2] - 1][regAddr[1:0]] = regWrData;
      end
      for (int w = 0; w < 3; w++) nx[w] = (mPend[w] & ~clrv[w]) | setv[w];
      if (c1 && nx[1] == 0) nx[0] &= ~(32'h4000_0000 & ~setv[0]);
      if (c2 && nx[2] == 0) nx[0] &= ~(32'h8000_0000 & ~setv[0]);
      for (int w = 0; w < 3; w++) mPend[w] = nx[w];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      chk("R3 irq vs model", {29'd0, irqOut}, {29'd0, mIrq()});
      chk("R12 read vs model", regRdData, mRead(regAddr));
    end
  end

  task automatic go();
    @(posedge clk); #1;
    evtValid = 0; hwClrValid = 0; regWrEn = 0;
  endtask
  task automatic ev(input logic [6:0] n);
    evtNum = n; evtValid = 1; go();
  endtask
  task automatic hc(input logic [6:0] n);
    hwClrNum = n; hwClrValid = 1; go();
  endtask
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1; go();
  endtask
  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    regAddr = a; #1;
    chk(tag, regRdData, exp);
    @(posedge clk); #1;
  endtask
  task automatic irqIs(input logic [2:0] exp, input string tag);
    chk(tag, {29'd0, irqOut}, {29'd0, exp});
  endtask

  initial begin
    #150000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    irqIs(3'b000, "R11 irq after reset");
    rd(4'd0, 32'h0, "R11 pend0 reset");
    rd(4'd2, 32'h0, "R11 pend2 reset");
    rd(4'd14, 32'h0, "R11 maskC2 reset");
    rstN = 1;
    @(posedge clk); #1;

    // R10 mask access and word index 3
    wr(4'd5, 32'h0000_0010);
    rd(4'd5, 32'h0000_0010, "R10 maskA word1 readback");
    wr(4'd7, 32'hFFFF_FFFF);
    rd(4'd7, 32'h0, "R10 word index 3 reads zero");

    // R1 R2 decode and cascade
    ev(7'h30);
    rd(4'd1, 32'h0001_0000, "R1 word1 bit16 set");
    rd(4'd0, 32'h4000_0000, "R2 cascade bit30 set");
    irqIs(3'b000, "R3 unmasked event quiet");
    ev(7'h24);
    irqIs(3'b001, "R3 output A on masked bit");

    // R6 word1 immune to software
    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, 32'h0001_0010, "R6 word1 unchanged by write");

    // R5 word0 write-one clear spares summary bits
    ev(7'h03);
    rd(4'd0, 32'h4000_0008, "R1 word0 bit3 set");
    wr(4'd0, 32'h0000_0008);
    rd(4'd0, 32'h4000_0000, "R5 bit3 cleared");
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, 32'h4000_0000, "R5 summary bit survives");

    // R4 mask change acts at once
    wr(4'd5, 32'h0);
    irqIs(3'b000, "R4 mask removed drops A");
    wr(4'd5, 32'h0000_0010);
    irqIs(3'b001, "R4 mask restored raises A");

    // R8 hardware clear and word1 drain
    hc(7'h24);
    irqIs(3'b000, "R4 A low after its bit cleared");
    rd(4'd0, 32'h4000_0000, "R8 summary kept while word1 nonempty");
    hc(7'h30);
    rd(4'd1, 32'h0, "R8 word1 empty");
    rd(4'd0, 32'h0, "R8 bit30 cleared on drain");

    // R7 word2 clearing and bit31
    ev(7'h45);
    rd(4'd0, 32'h8000_0000, "R2 cascade bit31 set");
    wr(4'd12, 32'h8000_0000);
    irqIs(3'b100, "R3 output C on summary bit");
    ev(7'h46);
    wr(4'd2, 32'h0000_0020);
    rd(4'd2, 32'h0000_0040, "R7 word2 partial clear");
    rd(4'd0, 32'h8000_0000, "R7 bit31 kept while nonempty");
    wr(4'd2, 32'h0000_0040);
    rd(4'd0, 32'h0, "R7 bit31 cleared on empty");
    irqIs(3'b000, "R4 C low after drain");

    // R8 word2 via hardware clear
    ev(7'h41); ev(7'h42);
    hc(7'h41);
    rd(4'd0, 32'h8000_0000, "R8 bit31 kept, word2 nonempty");
    hc(7'h42);
    rd(4'd0, 32'h0, "R8 bit31 cleared by hw drain");

    // R9 set wins over clear
    ev(7'h07);
    evtNum = 7'h07; evtValid = 1; hwClrNum = 7'h07; hwClrValid = 1; go();
    rd(4'd0, 32'h0000_0080, "R9 set beats hw clear");
    evtNum = 7'h07; evtValid = 1; regAddr = 4'd0; regWrData = 32'h80; regWrEn = 1; go();
    rd(4'd0, 32'h0000_0080, "R9 set beats sw clear");

    // R1 word index 3 events ignored
    ev(7'h65);
    rd(4'd0, 32'h0000_0080, "R1 word3 event ignored w0");
    rd(4'd1, 32'h0, "R1 word3 event ignored w1");
    rd(4'd2, 32'h0, "R1 word3 event ignored w2");

    // R3 output B, R12 immediate read
    wr(4'd8, 32'h0000_0080);
    irqIs(3'b010, "R3 output B");
    regAddr = 4'd8; #0.5;
    chk("R12 same-cycle read", regRdData, 32'h0000_0080);
    @(posedge clk); #1;
    wr(4'd0, 32'h0000_0080);
    irqIs(3'b000, "R4 B low after clear");

    // random traffic against the model
    for (int i = 0; i < 600; i++) begin
      evtValid   = ($urandom_range(0, 2) != 0);
      evtNum     = 7'($urandom_range(0, 127));
      hwClrValid = ($urandom_range(0, 2) == 0);
      hwClrNum   = 7'($urandom_range(0, 127));
      regWrEn    = ($urandom_range(0, 3) == 0);
      regAddr    = 4'($urandom_range(0, 15));
      regWrData  = $urandom();
      @(posedge clk); #1;
    end
    evtValid = 0; hwClrValid = 0; regWrEn = 0;
    repeat (2) @(posedge clk);
    #1;
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule